// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the array address for a synchronous burst memory. When an address strobe starts an access, it captures the full external address. From then on, the upper address bits stay frozen. Only the two least significant bits move, so a burst has four beats.

Each advance request steps the low bits to the next beat. A cycle without an advance keeps the current address. A static order input selects one of two walks:

- **Linear:** the start bits plus a beat count, wrapping modulo four.
- **Interleaved:** the start bits XORed with the beat count.

The block holds the captured start address and a separate beat count. Both outputs, the address and the beat position, come from those two registers. A surrounding cycle controller decides when a load or an advance is legal; this block acts on whatever it is given. A dummy read is simply another advance and steps the sequence in the same way as a normal read.

Top module: `burst_seq`

## Requirements
- R1: Address bits above the two low bits on `addr_o` equal the value captured by the most recent load, for as long as no new load occurs.
- R2: With `order_i` = 0 (linear), the low two bits of `addr_o` equal (captured low bits + `beat_o`) modulo 4. For example, a start of 01 walks 01, 10, 11, 00.
- R3: With `order_i` = 1 (interleaved), the low two bits of `addr_o` equal captured low bits XOR `beat_o`. For example, a start of 01 walks 01, 00, 11, 10.
- R4: The fourth advance after a load returns `beat_o` from 3 to 0, and `addr_o` to the loaded address.
- R5: `load_i` high at a rising edge makes `addr_o` equal `ext_addr_i` and `beat_o` equal 0 after that edge. This holds on every cycle, including back-to-back loads.
- R6: With `load_i` low, `step_i` high advances `beat_o` by one (mod 4) at the edge. `step_i` low leaves `beat_o` and `addr_o` unchanged.
- R7: When `load_i` and `step_i` are both high, the load wins: the beat count is 0 and the address is `ext_addr_i`.
- R8: While `rst_n` is low, `addr_o` and `beat_o` are all zeros.
- R9: `order_i` acts combinationally on the held start and beat. Changing it mid-burst changes the low bits of `addr_o` in the same cycle without changing `beat_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start strobe: capture `ext_addr_i` as the new burst start |
| step_i | input | 1 | Advance the burst by one beat |
| order_i | input | 1 | Order strap: 0 linear, 1 interleaved |
| ext_addr_i | input | ADDR_W | External address captured on a load |
| addr_o | output | ADDR_W | Current array address |
| beat_o | output | CNT_W | Beat position within the burst |

## Verification
A load and an advance can arrive in the same cycle. The stimulus table contains a row with both strobes high in the middle of an interleaved burst. The bench judges that row by requiring the new external address and a zero beat after the edge, rather than a stepped address. A second overlap, an order change while a burst is held, is provoked by flipping the strap on a hold row. It is judged by checking that the low bits follow the new formula while the beat count stays put.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl #(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] ext_addr_i,
    output logic [ADDR_W-1:0] start_q_o,
    output logic [CNT_W-1:0]  beat_q_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [CNT_W-1:0]  beat;
    } seq_state_t;

    localparam seq_state_t RESET_STATE = '{start: '0, beat: '0};

    seq_state_t state_d, state_q;

    // Next-state: a load beats an advance; no strobe holds (suspend).
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.start = ext_addr_i;
            state_d.beat  = '0;
        end else if (step_i) begin
            state_d.beat = state_q.beat + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RESET_STATE;
        else        state_q <= state_d;
    end

    assign start_q_o = state_q.start;
    assign beat_q_o  = state_q.beat;

    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_i) |=> (beat_q_o == CNT_W'($past(beat_q_o) + 1'b1))); // R6

    AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> ($stable(beat_q_o) && $stable(start_q_o))); // R6

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (beat_q_o == '0)); // R7

endmodule

// File: rtl/burst_seq_order.sv
module burst_seq_order
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  burst_order_e     order_i,
    input  logic [CNT_W-1:0] start_low_i,
    input  logic [CNT_W-1:0] beat_i,
    output logic [CNT_W-1:0] low_o
);

    logic [CNT_W-1:0] lin_low;
    logic [CNT_W-1:0] ilv_low;

    // Linear walk: wrapping add of the beat count onto the start bits.
    assign lin_low = start_low_i + beat_i;

    // Interleaved walk: per-bit XOR of start and beat.
    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
        assign ilv_low[b] = start_low_i[b] ^ beat_i[b];
    end

    always_comb begin
        unique case (order_i)
            ORD_INTERLEAVE: low_o = ilv_low;
            default:        low_o = lin_low;
        endcase
    end

    // Both walks agree at beat zero: the first beat is the loaded address.
    always_comb begin
        if (beat_i == '0) begin
            AST_FIRST_BEAT_IS_START: assert (lin_low == ilv_low); // R4
        end
    end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] ext_addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  beat_o
);

    localparam int HI_W = ADDR_W - CNT_W;

    logic [ADDR_W-1:0] start_q;
    logic [CNT_W-1:0]  beat_q;
    logic [CNT_W-1:0]  low_bits;
    burst_order_e      order_sel;

    assign order_sel = burst_order_e'(order_i);

    burst_seq_ctrl #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .step_i     (step_i),
        .ext_addr_i (ext_addr_i),
        .start_q_o  (start_q),
        .beat_q_o   (beat_q)
    );

    burst_seq_order #(
        .CNT_W (CNT_W)
    ) u_order (
        .order_i     (order_sel),
        .start_low_i (start_q[CNT_W-1:0]),
        .beat_i      (beat_q),
        .low_o       (low_bits)
    );

    assign addr_o = {start_q[ADDR_W-1:CNT_W], low_bits};
    assign beat_o = beat_q;

    AST_UPPER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (addr_o[ADDR_W-1:CNT_W] == $past(addr_o[ADDR_W-1:CNT_W]))); // R1

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && $stable(order_i)) |=> (addr_o == $past(ext_addr_i))); // R5

    AST_HI_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (HI_W > 0) |-> !$isunknown(addr_o)); // R8

endmodule

// File: tb/burst_seq_tb.sv
module burst_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 17;
    localparam int CNT_W  = 2;

    typedef struct packed {
        logic              load;
        logic              step;
        logic              order;
        logic [ADDR_W-1:0] ext;
        logic [ADDR_W-1:0] exp_addr;
        logic [CNT_W-1:0]  exp_beat;
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 18;
    // Each row: drive strobes/strap/address, clock once, compare outputs.
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 1'b0, 17'h12345, 17'h12345, 2'd0, 4'd5}, // R5 load, low 01
        '{1'b0, 1'b1, 1'b0, 17'h00000, 17'h12346, 2'd1, 4'd2}, // R2 linear 10
        '{1'b0, 1'b1, 1'b0, 17'h1FFFF, 17'h12347, 2'd2, 4'd2}, // R2 linear 11
        '{1'b0, 1'b1, 1'b0, 17'h00000, 17'h12344, 2'd3, 4'd1}, // R1 upper kept, 00
        '{1'b0, 1'b1, 1'b0, 17'h00000, 17'h12345, 2'd0, 4'd4}, // R4 wrap
        '{1'b0, 1'b0, 1'b0, 17'h0AAAA, 17'h12345, 2'd0, 4'd6}, // R6 suspend
        '{1'b1, 1'b0, 1'b1, 17'h0ABCD, 17'h0ABCD, 2'd0, 4'd5}, // R5 load, low 01
        '{1'b0, 1'b1, 1'b1, 17'h00000, 17'h0ABCC, 2'd1, 4'd3}, // R3 01^01=00
        '{1'b0, 1'b1, 1'b1, 17'h00000, 17'h0ABCF, 2'd2, 4'd3}, // R3 01^10=11
        '{1'b0, 1'b0, 1'b1, 17'h00000, 17'h0ABCF, 2'd2, 4'd6}, // R6 suspend
        '{1'b0, 1'b1, 1'b1, 17'h00000, 17'h0ABCE, 2'd3, 4'd3}, // R3 01^11=10
        '{1'b0, 1'b1, 1'b1, 17'h00000, 17'h0ABCD, 2'd0, 4'd4}, // R4 wrap
        '{1'b0, 1'b1, 1'b1, 17'h00000, 17'h0ABCC, 2'd1, 4'd3}, // R3 step again
        '{1'b1, 1'b1, 1'b1, 17'h1FFFE, 17'h1FFFE, 2'd0, 4'd7}, // R7 load beats step
        '{1'b1, 1'b0, 1'b0, 17'h00005, 17'h00005, 2'd0, 4'd5}, // R5 back-to-back
        '{1'b0, 1'b1, 1'b0, 17'h00000, 17'h00006, 2'd1, 4'd2}, // R2 01+01=10
        '{1'b0, 1'b0, 1'b1, 17'h00000, 17'h00004, 2'd1, 4'd9}, // R9 strap flip
        '{1'b0, 1'b1, 1'b1, 17'h00000, 17'h00007, 2'd2, 4'd3}  // R3 01^10=11
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_i = 1'b0;
    logic              step_i = 1'b0;
    logic              order_i = 1'b0;
    logic [ADDR_W-1:0] ext_addr_i = '0;
    logic [ADDR_W-1:0] addr_o;
    logic [CNT_W-1:0]  beat_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .step_i     (step_i),
        .order_i    (order_i),
        .ext_addr_i (ext_addr_i),
        .addr_o     (addr_o),
        .beat_o     (beat_o)
    );

    task automatic check(input string req, input logic [ADDR_W-1:0] ea,
                         input logic [CNT_W-1:0] eb);
        n_checks++;
        if (addr_o !== ea || beat_o !== eb) begin
            n_fails++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     req, addr_o, beat_o, ea, eb);
        end
    endtask

    task automatic drive(input logic ld, input logic st, input logic od,
                         input logic [ADDR_W-1:0] ad);
        @(negedge clk);
        load_i = ld; step_i = st; order_i = od; ext_addr_i = ad;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R8: outputs zero during reset, even with strobes active.
        load_i = 1'b1; ext_addr_i = 17'h1ABCD; step_i = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R8 reset", '0, '0);
        @(negedge clk);
        load_i = 1'b0; step_i = 1'b0; ext_addr_i = '0;
        rst_n = 1'b1;
        #1;
        check("R8 after release", '0, '0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].load, TBL[i].step, TBL[i].order, TBL[i].ext);
            check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].exp_addr, TBL[i].exp_beat);
        end

        // R9: strap change acts at once, before any clock edge.
        @(negedge clk);
        load_i = 1'b0; step_i = 1'b0; order_i = 1'b0;
        #1;
        check("R9 strap back to linear", 17'h00007, 2'd2);

        // R5: load every cycle, each new address takes effect.
        for (int k = 0; k < 4; k++) begin
            drive(1'b1, 1'b0, 1'b1, 17'h10000 + 17'(k * 5));
            check("R5 load each cycle", 17'h10000 + 17'(k * 5), 2'd0);
        end

        // R4: full interleaved lap from start 10 returns to start.
        drive(1'b1, 1'b0, 1'b1, 17'h08882);
        drive(1'b0, 1'b1, 1'b1, '0);
        check("R3 10^01", 17'h08883, 2'd1);
        drive(1'b0, 1'b1, 1'b1, '0);
        check("R3 10^10", 17'h08880, 2'd2);
        drive(1'b0, 1'b1, 1'b1, '0);
        check("R3 10^11", 17'h08881, 2'd3);
        drive(1'b0, 1'b1, 1'b1, '0);
        check("R4 lap end", 17'h08882, 2'd0);

        // R8: reset mid-burst clears address and beat.
        drive(1'b0, 1'b1, 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R8 mid-burst reset", '0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        step_i = 1'b0;

        drive(1'b0, 1'b1, 1'b0, '0);
        check("R6 step after reset", 17'h00001, 2'd1);

        finish_run();
    end

endmodule